// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small microcontroller core. A call or push stores the address of the following instruction. A return or pop hands back the entry on top. The storage is a ring of 32 entries of 21 bits each, and a 5-bit pointer selects one of them. Each of the 32 pointer values selects a real slot. Slot 0 is the one in use when the stack is empty.

Software reaches the stack through one byte-wide register window. Select codes 0, 1 and 2 pick the low, middle and upper byte of the entry that the pointer selects. Select code 3 picks the pointer itself. Both kinds of register can be read and written. A program can therefore build or change call frames without using call or return, and it can move the pointer to any slot.

The core presents a pop and reads the returned address from `tos_o` in the same cycle. The pointer steps down at the clock edge that ends that cycle. A push moves the pointer up and writes the new entry at that same edge, so the pushed address shows on `tos_o` from the next cycle on.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer and all 32 entries become zero.
- R2: A push increments the pointer and then writes `push_addr_i` into the slot at the new pointer. From the next cycle on, `tos_o` shows that value.
- R3: During a pop cycle, `tos_o` holds the entry at the current pointer, which is the returned address. At the clock edge that ends the cycle, the pointer decrements.
- R4: The pointer wraps modulo 32. A push at pointer 31 moves it to 0, and a pop at pointer 0 moves it to 31.
- R5: If push and pop are both high in one cycle, the pop is ignored and the push takes effect.
- R6: `reg_rdata_o` is combinational from `reg_sel_i`. Select 0 gives entry bits 7:0, select 1 gives bits 15:8, and select 2 gives bits 20:16 with three zero bits on top.
- R7: A register write with select 0, 1 or 2 replaces only that byte of the entry the pointer selects. The other bytes and all other entries keep their values.
- R8: A write with select 2 stores only `reg_wdata_i[4:0]`, as entry bits 20:16.
- R9: Select 3 reads the pointer as `{3'b000, pointer}`. A write with select 3 loads `reg_wdata_i[4:0]` into the pointer, and bits 7:5 are ignored.
- R10: A register write in a cycle that has a push or a pop is ignored.
- R11: Entries below the top are kept. Pushing 32 values and then popping 32 times returns them in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push `push_addr_i` |
| pop_i | input | 1 | Pop the top entry |
| push_addr_i | input | 21 | Address to store on a push |
| tos_o | output | 21 | Entry at the current pointer |
| reg_sel_i | input | 2 | Register select: 0/1/2 selects a byte of the top entry, 3 selects the pointer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
On every cycle, the assertions check how the pointer moves: the increment, the decrement, the wrap in both directions, push winning over pop, pointer loads and reset. They also check that a pushed value appears on top, that a byte write changes only its own byte, and that a write to the upper byte is cut to 5 bits. Other behaviours need the bench's scenarios. A write that is blocked by a push or pop must leave no trace in the entry. Deep entries must keep their contents across a full wrap. Each slot must hold exactly what reset left in it.

// File: rtl/ras_pkg.sv
// Package for the return-address stack.
// Holds the register-select encoding shared by the register window and the top module.
package ras_pkg;
    // Register window select codes (fixed encoding, see R6/R9)
    typedef enum logic [1:0] {
        SEL_TOS_LO  = 2'd0,
        SEL_TOS_MID = 2'd1,
        SEL_TOS_HI  = 2'd2,
        SEL_PTR     = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ras_ptr.sv
// Stack pointer for the return-address stack.
// Steps up on a push and down on a pop; push wins over pop. A load sets it directly.
// Assumes the caller never raises ld together with push or pop.
module ras_ptr #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] TOPV = {PTR_W{1'b1}};

    // Update the pointer: reset, push step, pop step or direct load
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (push) ptr <= ptr + ONE;
        else if (pop)  ptr <= ptr - ONE;
        else if (ld)   ptr <= ld_val;
    end

    p_reset_ptr_r1: assert property (@(posedge clk) !rst_n |=> (ptr == '0));
    p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (ptr == $past(ptr) + ONE));
    p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (ptr == $past(ptr) - ONE));
    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && ptr == TOPV) |=> (ptr == '0));
    p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && ptr == '0) |=> (ptr == TOPV));
    p_push_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (ptr != $past(ptr) - ONE));
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !push && !pop) |=> (ptr == $past(ld_val)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !push && !pop) |=> $stable(ptr));
endmodule

// File: rtl/ras_store.sv
// Entry storage for the return-address stack: one flop word per slot.
// One write port and one combinational read port. Reset clears every slot.
module ras_store #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [ADDR_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [ADDR_W-1:0] mem [DEPTH];

    // Clear all slots on reset, else write the addressed slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) mem[s] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the selected slot
    assign rdata = mem[raddr];

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ras_regif.sv
// Byte register window over the top entry and the pointer.
// Reads out the selected byte or the pointer. Also builds the entry value for a byte write:
// the old entry with one byte replaced, cut to the entry width.
// Assumes PTR_W <= BYTE_W and an entry of at most three bytes.
module ras_regif
    import ras_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5,
    parameter int BYTE_W = 8
) (
    input  reg_sel_e          sel,
    input  logic [ADDR_W-1:0] tos,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] merged
);
    // Read mux: pointer zero-extended, or one byte of the entry
    always_comb begin
        rdata = '0;
        if (sel == SEL_PTR) begin
            rdata[PTR_W-1:0] = ptr;
        end else begin
            for (int k = 0; k < BYTE_W; k++) begin
                if (int'(sel) * BYTE_W + k < ADDR_W)
                    rdata[k] = tos[int'(sel) * BYTE_W + k];
            end
        end
    end

    // Byte replace: bits in the selected byte come from wdata, the rest from tos
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            if (i / BYTE_W == int'(sel)) merged[i] = wdata[i % BYTE_W];
            else                         merged[i] = tos[i];
        end
    end
endmodule

// File: rtl/ret_addr_stack.sv
// Return-address stack top level.
// Push/pop ring of 2**PTR_W entries of ADDR_W bits, plus a byte register window on the
// top entry and the pointer. Priority: push, then pop, then register write.
// A register write that shares a cycle with a push or pop is dropped.
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    output logic [ADDR_W-1:0] tos_o,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o
);
    localparam int HI_LSB = 2 * BYTE_W;
    localparam int HI_W   = ADDR_W - HI_LSB;

    reg_sel_e          sel;
    logic [PTR_W-1:0]  ptr;
    logic              wr_ok, ptr_ld, tos_wr, st_we;
    logic [PTR_W-1:0]  st_waddr;
    logic [ADDR_W-1:0] st_wdata, merged;

    assign sel = reg_sel_e'(reg_sel_i);

    // Register write only when no stack operation is in the same cycle (R10)
    assign wr_ok  = reg_wr_i && !push_i && !pop_i;
    assign ptr_ld = wr_ok && (sel == SEL_PTR);
    assign tos_wr = wr_ok && (sel != SEL_PTR);

    // Write port: a push goes one slot above the pointer, a byte write goes into the top slot
    assign st_we    = push_i || tos_wr;
    assign st_waddr = push_i ? ptr + PTR_W'(1) : ptr;
    assign st_wdata = push_i ? push_addr_i : merged;

    ras_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i),
        .ld(ptr_ld), .ld_val(reg_wdata_i[PTR_W-1:0]), .ptr(ptr)
    );

    ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
        .wdata(st_wdata), .raddr(ptr), .rdata(tos_o)
    );

    ras_regif #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_regif (
        .sel(sel), .tos(tos_o), .ptr(ptr), .wdata(reg_wdata_i),
        .rdata(reg_rdata_o), .merged(merged)
    );

    p_reset_tos_r1: assert property (@(posedge clk) !rst_n |=> (tos_o == '0));
    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (tos_o == $past(push_addr_i)));
    p_push_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i ##1 (pop_i && !push_i)) |=> (tos_o == $past(tos_o, 2)));
    p_lo_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == SEL_TOS_LO) |=>
        (tos_o[BYTE_W-1:0] == $past(reg_wdata_i)) &&
        (tos_o[ADDR_W-1:BYTE_W] == $past(tos_o[ADDR_W-1:BYTE_W])));
    p_hi_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == SEL_TOS_HI) |=>
        (tos_o[ADDR_W-1:HI_LSB] == $past(reg_wdata_i[HI_W-1:0])) &&
        (tos_o[HI_LSB-1:0] == $past(tos_o[HI_LSB-1:0])));
    p_ptr_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PTR) |-> (reg_rdata_o[BYTE_W-1:PTR_W] == '0));
endmodule

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
    localparam int AW = 21;

    typedef struct packed {
        logic          push;
        logic          pop;
        logic [AW-1:0] addr;
        logic          wr;
        logic [1:0]    wsel;
        logic [7:0]    wdata;
        logic [1:0]    csel;
        logic [AW-1:0] exp_tos;
        logic [7:0]    exp_rd;
        logic [7:0]    rq;
    } vec_t;

    // push pop addr wr wsel wdata | csel exp_tos exp_rd | req
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,21'h012345,1'b0,2'd0,8'h00, 2'd0,21'h012345,8'h45, 8'd2},  // R2
        '{1'b1,1'b0,21'h1ABCDE,1'b0,2'd0,8'h00, 2'd1,21'h1ABCDE,8'hBC, 8'd6},  // R6
        '{1'b0,1'b0,21'h000000,1'b0,2'd0,8'h00, 2'd2,21'h1ABCDE,8'h1A, 8'd6},  // R6
        '{1'b0,1'b0,21'h000000,1'b0,2'd0,8'h00, 2'd3,21'h1ABCDE,8'h02, 8'd9},  // R9
        '{1'b0,1'b0,21'h000000,1'b1,2'd0,8'h77, 2'd0,21'h1ABC77,8'h77, 8'd7},  // R7
        '{1'b0,1'b0,21'h000000,1'b1,2'd2,8'hFF, 2'd2,21'h1FBC77,8'h1F, 8'd8},  // R8
        '{1'b0,1'b0,21'h000000,1'b1,2'd1,8'h00, 2'd1,21'h1F0077,8'h00, 8'd7},  // R7
        '{1'b1,1'b1,21'h000111,1'b0,2'd0,8'h00, 2'd3,21'h000111,8'h03, 8'd5},  // R5
        '{1'b0,1'b1,21'h000000,1'b0,2'd0,8'h00, 2'd3,21'h1F0077,8'h02, 8'd3},  // R3
        '{1'b0,1'b1,21'h000000,1'b1,2'd0,8'h55, 2'd0,21'h012345,8'h45, 8'd10}, // R10
        '{1'b0,1'b0,21'h000000,1'b1,2'd3,8'hE2, 2'd0,21'h1F0077,8'h77, 8'd10}, // R10 + R9
        '{1'b1,1'b0,21'h0ABCDE,1'b1,2'd0,8'h99, 2'd0,21'h0ABCDE,8'hDE, 8'd10}, // R10
        '{1'b0,1'b0,21'h000000,1'b1,2'd3,8'h00, 2'd3,21'h000000,8'h00, 8'd9},  // R9
        '{1'b0,1'b1,21'h000000,1'b0,2'd0,8'h00, 2'd3,21'h000000,8'h1F, 8'd4},  // R4
        '{1'b1,1'b0,21'h100001,1'b0,2'd0,8'h00, 2'd3,21'h100001,8'h00, 8'd4}   // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, reg_wr_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic [1:0]    reg_sel_i = '0;
    logic [7:0]    reg_wdata_i = '0;
    logic [AW-1:0] tos_o;
    logic [7:0]    reg_rdata_o;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_addr_i(push_addr_i), .tos_o(tos_o), .reg_sel_i(reg_sel_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then release the strobes just after the edge
    task automatic step(input logic pu, input logic po, input logic [AW-1:0] a,
                        input logic w, input logic [1:0] ws, input logic [7:0] wd);
        @(negedge clk);
        push_i = pu; pop_i = po; push_addr_i = a;
        reg_wr_i = w; reg_sel_i = ws; reg_wdata_i = wd;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0; reg_wr_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s);
        reg_sel_i = s;
        #0.5;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state after reset
        peek(2'd3); chk("R1 ptr", reg_rdata_o, 8'h00);
        chk("R1 tos", tos_o, 21'h0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            step(VEC[v].push, VEC[v].pop, VEC[v].addr, VEC[v].wr, VEC[v].wsel, VEC[v].wdata);
            peek(VEC[v].csel);
            chk($sformatf("R%0d tos v%0d", VEC[v].rq, v), tos_o, VEC[v].exp_tos);
            chk($sformatf("R%0d rd v%0d", VEC[v].rq, v), reg_rdata_o, VEC[v].exp_rd);
        end

        // R3: value returned during the pop cycle (pointer 0 holds 100001, then 31 holds 0)
        @(negedge clk); pop_i = 1'b1; #0.5;
        chk("R3 pop value", tos_o, 21'h100001);
        @(posedge clk); #1; pop_i = 1'b0; peek(2'd3);
        chk("R3 ptr after pop", reg_rdata_o, 8'h1F);

        // R1: reset in mid-use clears the pointer and the contents
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; @(negedge clk); rst_n = 1'b1;
        peek(2'd3); chk("R1 ptr after reset", reg_rdata_o, 8'h00);
        step(1'b0, 1'b0, '0, 1'b1, 2'd3, 8'h05);
        peek(2'd0); chk("R1 slot 5 cleared", tos_o, 21'h0);
        step(1'b0, 1'b0, '0, 1'b1, 2'd3, 8'h00);

        // R11: fill all 32 slots, then unwind in reverse order
        for (int i = 1; i <= 32; i++)
            step(1'b1, 1'b0, 21'((i * 32'h0F0F1) ^ 32'h15A5A), 1'b0, 2'd0, 8'h00);
        peek(2'd3); chk("R11 ptr wrapped", reg_rdata_o, 8'h00);
        for (int i = 32; i >= 1; i--) begin
            @(negedge clk); pop_i = 1'b1; #0.5;
            chk($sformatf("R11 pop %0d", i), tos_o, 21'((i * 32'h0F0F1) ^ 32'h15A5A));
            @(posedge clk); #1; pop_i = 1'b0;
        end
        peek(2'd3); chk("R11 ptr after unwind", reg_rdata_o, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule